// File: doc/BRIEF.md
# Two-Colour Pattern Expander

This block is a small bus-readable register peripheral that widens a monochrome pattern into packed colour indices. Software writes two 4-bit colour indices and a 16-bit pattern word with one bit per pixel. It then reads four expansion words. Each expansion word carries four 4-bit pixels, and each pixel is the "set" colour when its pattern bit is 1 and the "clear" colour when its pattern bit is 0.

Writes take effect on the clock edge. Reads are combinational from the stored registers, so a read in the cycle after a write already sees the new values. Byte and word accesses use the same bus. A byte access picks its lane with address bit 0.

Top module: `font_expander`

## Requirements
- R1: After reset, both colour indices and the pattern are zero, so every readable address returns 0.
- R2: Word address 0x0 is the colour register. Bits 3:0 hold the clear colour and bits 7:4 hold the set colour. A word write stores wdata[7:0], and a word read returns {8'h00, set, clear}.
- R3: Word address 0x2 holds the pattern. A word write stores wdata[15:0], and a word read returns it.
- R4: Addresses 0x8, 0xA, 0xC and 0xE return expansion words 0 to 3. Word k covers pattern bits 15-4k down to 12-4k. The most significant nibble comes from the highest of these bits, and each nibble is the set colour when its bit is 1 and the clear colour otherwise.
- R5: A byte read (byte_acc=1) returns, in rdata[7:0], the upper byte of the addressed word when addr[0]=0 and the lower byte when addr[0]=1. In that case rdata[15:8] is 0.
- R6: A byte write stores wdata[7:0] into the upper byte of the word when addr[0]=0 and into the lower byte when addr[0]=1, leaving the other byte unchanged. The upper byte of the colour register has no storage, so a byte write to 0x0 changes nothing.
- R7: Writes to the expansion addresses change neither the colours nor the pattern.
- R8: A read in the cycle after a write of the colours or the pattern returns values built from the newly written contents.
- R9: Addresses 0x4 and 0x6 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe for the current cycle |
| byte_acc | input | 1 | 1 = byte access, 0 = word access |
| addr | input | 4 | Byte address within the block |
| wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rdata | output | 16 | Combinational read data |

## Verification
The bench aims at the bit-to-nibble mapping. It uses patterns with single bits set and sparse bits set, so that a reversed word order or a reversed nibble order inside a word would put a colour on the wrong pixel. It uses colour pairs that differ in every bit, so that swapped colour roles show at once. It checks byte lanes on reads and writes. A design that inverted address bit 0 would read or write the wrong half. A design that gave the colour register's upper byte storage would disturb the colours. It writes to the expansion and unused addresses and then reads everything back, which catches a decoder that lets those writes reach the stored state.

// File: rtl/font_expander.sv
module font_expander #(
  parameter int PIX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        byte_acc,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  localparam int PIX_PER_WORD = DATA_W / PIX_W;
  localparam int N_WORDS      = DATA_W / PIX_PER_WORD;
  localparam int HALF         = DATA_W / 2;

  logic [PIX_W-1:0]  col0_q, col1_q;
  logic [DATA_W-1:0] pat_q;
  logic [N_WORDS-1:0][DATA_W-1:0] exp_word;
  logic [DATA_W-1:0] word_rd;

  wire sel_col = (addr[3:1] == 3'd0);
  wire sel_pat = (addr[3:1] == 3'd1);
  wire sel_exp = addr[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col0_q <= '0;
      col1_q <= '0;
      pat_q  <= '0;
    end else if (we) begin
      if (sel_col && (!byte_acc || addr[0])) begin
        col0_q <= wdata[PIX_W-1:0];
        col1_q <= wdata[2*PIX_W-1:PIX_W];
      end
      if (sel_pat) begin
        if (!byte_acc)
          pat_q <= wdata[DATA_W-1:0];
        else if (addr[0])
          pat_q[HALF-1:0] <= wdata[HALF-1:0];
        else
          pat_q[DATA_W-1:HALF] <= wdata[HALF-1:0];
      end
    end
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    for (genvar p = 0; p < PIX_PER_WORD; p++) begin : g_pix
      assign exp_word[w][p*PIX_W +: PIX_W] =
        pat_q[DATA_W - PIX_PER_WORD*(w+1) + p] ? col1_q : col0_q;
    end
  end

  always_comb begin
    word_rd = '0;
    if (sel_exp)      word_rd = exp_word[addr[2:1]];
    else if (sel_pat) word_rd = pat_q;
    else if (sel_col) word_rd = {{(DATA_W-2*PIX_W){1'b0}}, col1_q, col0_q};
  end

  assign rdata = !byte_acc ? word_rd :
                 {{HALF{1'b0}}, addr[0] ? word_rd[HALF-1:0] : word_rd[DATA_W-1:HALF]};

  a_r7_exp_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel_exp) |=> ($stable(pat_q) && $stable(col0_q) && $stable(col1_q)));

  a_r3_pattern_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !byte_acc && sel_pat) |=> (pat_q == $past(wdata)));

  a_r6_low_byte_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (we && byte_acc && sel_pat && addr[0]) |=> (pat_q[DATA_W-1:HALF] == $past(pat_q[DATA_W-1:HALF])));

  a_r6_colour_high_byte_void: assert property (@(posedge clk) disable iff (!rst_n)
    (we && byte_acc && sel_col && !addr[0]) |=> ($stable(col0_q) && $stable(col1_q)));

  a_r5_byte_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc |-> (rdata[DATA_W-1:HALF] == '0));

  a_r4_nibbles_are_colours: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_exp && !byte_acc) |-> ((rdata[3:0] == col0_q || rdata[3:0] == col1_q) &&
                               (rdata[15:12] == col0_q || rdata[15:12] == col1_q)));
endmodule

// File: tb/font_expander_test.sv
module font_expander_test;
  logic clk = 0, rst_n = 0, we = 0, byte_acc = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  int m_c0 = 0, m_c1 = 0, m_pat = 0;
  string last_tag = "";

  always #4 clk = ~clk;

  font_expander uut (.clk(clk), .rst_n(rst_n), .we(we), .byte_acc(byte_acc),
                     .addr(addr), .wdata(wdata), .rdata(rdata));

  function automatic int model_read(int a, bit b);
    int w = 0;
    if (a >= 8) begin
      int k = (a >> 1) & 3;
      for (int n = 0; n < 4; n++) begin
        int bitpos = 12 - 4*k + n;
        int c = ((m_pat >> bitpos) & 1) ? m_c1 : m_c0;
        w = w | (c << (4*n));
      end
    end else if ((a >> 1) == 0) w = (m_c1 << 4) | m_c0;
    else if ((a >> 1) == 1) w = m_pat;
    if (b) w = (a & 1) ? (w & 255) : ((w >> 8) & 255);
    return w;
  endfunction

  task automatic model_write(int a, bit b, int d);
    if ((a >> 1) == 0) begin
      if (!b || (a & 1)) begin m_c0 = d & 15; m_c1 = (d >> 4) & 15; end
    end else if ((a >> 1) == 1) begin
      if (!b) m_pat = d & 16'hffff;
      else if (a & 1) m_pat = (m_pat & 16'hff00) | (d & 255);
      else m_pat = (m_pat & 255) | ((d & 255) << 8);
    end
  endtask

  task automatic op(bit w, bit b, int a, int d, string tag);
    int exp;
    @(negedge clk);
    we = w; byte_acc = b; addr = a[3:0]; wdata = d[15:0];
    #2;
    exp = model_read(a, b);
    checks++;
    if (rdata !== exp[15:0]) begin
      fails++;
      $display("FAIL %s addr=%0h byte=%0b actual=%04h expected=%04h", tag, a, b, rdata, exp[15:0]);
    end
    @(posedge clk);
    if (w) model_write(a, b, d);
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < 16; a += 2) op(0, 0, a, 0, tag);
  endtask

  initial begin
    #(8*100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    read_all("R1");
    for (int a = 0; a < 16; a++) op(0, 1, a, 0, "R1");

    op(1, 0, 0, 16'h00a5, "R2"); op(0, 0, 0, 0, "R2");
    op(1, 0, 2, 16'h8001, "R3"); op(0, 0, 2, 0, "R3");
    read_all("R4");
    op(1, 0, 2, 16'h1248, "R8"); read_all("R4");
    op(1, 0, 0, 16'hff0f, "R8"); read_all("R4");
    op(1, 0, 2, 16'hf05a, "R8");
    for (int a = 0; a < 16; a++) op(0, 1, a, 0, "R5");

    op(1, 1, 3, 16'h0033, "R6"); op(0, 0, 2, 0, "R6");
    op(1, 1, 2, 16'h00c4, "R6"); op(0, 0, 2, 0, "R6");
    op(1, 1, 0, 16'h0077, "R6"); op(0, 0, 0, 0, "R6");
    op(1, 1, 1, 16'h0069, "R6"); read_all("R6");

    for (int a = 8; a < 16; a++) op(1, a[0], a, 16'hbeef, "R7");
    read_all("R7");
    for (int a = 4; a < 8; a++) op(1, a[0], a, 16'h5a5a, "R9");
    read_all("R9");

    for (int i = 0; i < 400; i++) begin
      int a = $urandom_range(0, 15);
      bit b = $urandom_range(0, 1) == 1;
      bit w = $urandom_range(0, 2) == 0;
      op(w, b, a, $urandom_range(0, 16'hffff), w ? "R8" : (b ? "R5" : "R4"));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule